// File: doc/BRIEF.md
# Multi-channel DMA control register file

This block is the control and status register bank that sits in front of an eight-channel scatter-gather DMA engine. A simple 32-bit register bus selects a channel through the upper address bits and a register through the lower seven bits. Each channel's window is 0x80 bytes wide. For every channel the bank stores the source and destination addresses, the stream port selections, the transfer options, the direct-mode byte count, the linked-list head, the scheduling priority and weight, and the interrupt enables. All of these stored values are driven straight out to the channel engine.

Writing the channel status register sends single-cycle command pulses to the engine: start, linked-list start, self-restart and stop. The engine returns a busy flag, a progress count and event pulses for each channel. The bank latches enabled events into write-one-to-clear pending bits and raises one interrupt line per channel.

Top module: `dmareg_top`

## Requirements
- R1: Address bits [9:7] select the channel and bits [6:0] select the register. A write reaches only the addressed channel, and a read returns that channel's own value.
- R2: Reads return only the stored fields, with every other bit 0. The stored fields are: input port [7:0], input options bits 12..14, output stream [23:0], output options bits 12..13, priority [2:0], weight [10:8], interrupt enables bits 0, 2, 3 and 4. Source, destination, byte count (0x20) and list head (0x70) keep all 32 bits.
- R3: The configuration outputs follow the registers from the cycle after the write. The output stream register at 0x18 carries the output port in [7:0], the source ID in [15:8] and the sink ID in [23:16]. The input options at 0x0C map onto the 3-bit output as {wait-on-packet (bit 14), completion-on-packet (bit 13), memory source (bit 12)}.
- R4: A read of the status register at 0x2C returns the channel's busy input in bit 0, with all other bits 0.
- R5: Writing 1 to status bit 0 gives a one-cycle start pulse, and writing 1 to bit 4 gives a one-cycle linked-list start pulse. Each pulse is high in the cycle after the write. Both are suppressed when the channel's busy input is 1 at the write.
- R6: Writing 1 to status bit 1 gives a one-cycle self-restart pulse, and writing 1 to bit 2 gives a one-cycle stop pulse. Both are issued whatever the busy state.
- R7: The pending register at 0x54 latches an event only if its enable bit at 0x50 is set. The event bits are: 0 end of descriptor, 2 out of busy, 3 descriptor status updated, 4 packet done.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: A falling edge on a channel's busy input is the out-of-busy event (pending bit 2).
- R10: A channel's interrupt output is high exactly when some pending bit has its enable set. Clearing the enable masks the output but leaves the pending bit readable.
- R11: A read at 0x60 returns the engine's progress count for that channel.
- R12: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register and issues no pulse.
- R13: After reset all stored fields, pending bits, pulses and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 10 | Byte address: channel [9:7], offset [6:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| busy_i | input | 8 | Per-channel busy from engine |
| progress_i | input | 256 | Per-channel progress count, 32 bits each |
| evt_desc_end_i | input | 8 | End-of-descriptor event pulses |
| evt_desc_upd_i | input | 8 | Descriptor-status-updated event pulses |
| evt_pkt_done_i | input | 8 | Packet-done event pulses |
| src_addr_o | output | 256 | Source addresses |
| dst_addr_o | output | 256 | Destination addresses |
| byte_cnt_o | output | 256 | Direct-mode byte counts |
| ll_head_o | output | 256 | Linked-list head addresses |
| in_port_o | output | 64 | Input stream port per channel |
| in_cfg_o | output | 24 | Input options per channel, 3 bits each |
| out_stream_o | output | 192 | Output port, source ID and sink ID, 24 bits each |
| out_cfg_o | output | 16 | {end-of-packet, memory destination} per channel |
| prio_o | output | 24 | Priority per channel |
| weight_o | output | 24 | Weight per channel |
| start_o | output | 8 | Direct start pulses |
| ll_start_o | output | 8 | Linked-list start pulses |
| restart_o | output | 8 | Self-restart pulses |
| stop_o | output | 8 | Stop pulses |
| irq_o | output | 8 | Per-channel interrupt |

## Verification
A wrong channel decode shows at once: the value written to one channel turns up at another channel's configuration outputs one cycle after the write, or a readback returns a different channel's value. A stuck or mis-set pending bit makes irq_o wrong in the cycle after the event edge, and the 0x54 read exposes it on the next access. A wrong busy gate or a wrong pulse register shows on the command outputs in the cycle right after the status write, and again one cycle later if a pulse lasts too long.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int DATA_W = 32;
    localparam int OFS_W  = 7;
    localparam int IRQ_W  = 5;

    // Event bit positions, shared by the enable and pending registers
    localparam int EV_DESC_END = 0;
    localparam int EV_IDLE     = 2;
    localparam int EV_DESC_UPD = 3;
    localparam int EV_PKT_DONE = 4;
    localparam logic [IRQ_W-1:0] IRQ_MASK = 5'b11101;

    typedef enum logic [3:0] {
        R_SRC, R_INPORT, R_INCFG, R_DST, R_OUTSTR, R_OUTCFG, R_BYTES,
        R_STATUS, R_PRIO, R_IE, R_IP, R_PROG, R_LLHEAD, R_NONE
    } reg_id_e;

    typedef struct packed {
        logic [31:0]      src;
        logic [31:0]      dst;
        logic [31:0]      bytes;
        logic [31:0]      ll_head;
        logic [7:0]       in_port;
        logic [2:0]       in_cfg;
        logic [23:0]      out_stream;
        logic [1:0]       out_cfg;
        logic [2:0]       prio;
        logic [2:0]       weight;
        logic [IRQ_W-1:0] ie;
    } ch_cfg_t;

    function automatic reg_id_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            7'h00:   return R_SRC;
            7'h08:   return R_INPORT;
            7'h0C:   return R_INCFG;
            7'h10:   return R_DST;
            7'h18:   return R_OUTSTR;
            7'h1C:   return R_OUTCFG;
            7'h20:   return R_BYTES;
            7'h2C:   return R_STATUS;
            7'h44:   return R_PRIO;
            7'h50:   return R_IE;
            7'h54:   return R_IP;
            7'h60:   return R_PROG;
            7'h70:   return R_LLHEAD;
            default: return R_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_AW + OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_id_e           rid
);
    always_comb begin
        ch_hit = '0;
        for (int i = 0; i < NUM_CH; i++)
            ch_hit[i] = (addr[ADDR_W-1:OFS_W] == CH_AW'(i));
    end

    assign rid = decode_ofs(addr[OFS_W-1:0]);
endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq
    import dmareg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] ie,
    input  logic [IRQ_W-1:0] ev_in,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_mask,
    output logic [IRQ_W-1:0] pend,
    output logic             irq_o
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~(clr_we ? clr_mask : '0)) | (ev_in & ie);
    end

    assign irq_o = |(pend & ie);

    // A new pending bit needs its enable in the cycle it was latched
    p_pend_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        ((pend & ~$past(pend) & ~$past(ie)) == '0));

    // Enabled event always lands, even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        ((pend & $past(ev_in & ie)) == $past(ev_in & ie)));

    // A clear with no competing event empties the addressed bits
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_we) && ($past(ev_in & ie) == '0)) |->
            ((pend & $past(clr_mask)) == '0));
endmodule

// File: rtl/dmareg_channel.sv
module dmareg_channel
    import dmareg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  reg_id_e     rid,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        busy_i,
    input  logic [31:0] progress_i,
    input  logic        evt_desc_end_i,
    input  logic        evt_desc_upd_i,
    input  logic        evt_pkt_done_i,
    output ch_cfg_t     cfg_o,
    output logic        start_o,
    output logic        ll_start_o,
    output logic        restart_o,
    output logic        stop_o,
    output logic        irq_o
);
    logic             busy_q;
    logic [IRQ_W-1:0] ev_vec;
    logic [IRQ_W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o      <= '0;
            busy_q     <= 1'b0;
            start_o    <= 1'b0;
            ll_start_o <= 1'b0;
            restart_o  <= 1'b0;
            stop_o     <= 1'b0;
        end else begin
            busy_q     <= busy_i;
            start_o    <= 1'b0;
            ll_start_o <= 1'b0;
            restart_o  <= 1'b0;
            stop_o     <= 1'b0;
            if (wr_en) begin
                case (rid)
                    R_SRC:    cfg_o.src        <= wdata;
                    R_DST:    cfg_o.dst        <= wdata;
                    R_BYTES:  cfg_o.bytes      <= wdata;
                    R_LLHEAD: cfg_o.ll_head    <= wdata;
                    R_INPORT: cfg_o.in_port    <= wdata[7:0];
                    R_INCFG:  cfg_o.in_cfg     <= wdata[14:12];
                    R_OUTSTR: cfg_o.out_stream <= wdata[23:0];
                    R_OUTCFG: cfg_o.out_cfg    <= wdata[13:12];
                    R_PRIO: begin
                        cfg_o.prio   <= wdata[2:0];
                        cfg_o.weight <= wdata[10:8];
                    end
                    R_IE:     cfg_o.ie         <= wdata[IRQ_W-1:0] & IRQ_MASK;
                    R_STATUS: begin
                        start_o    <= wdata[0] & ~busy_i;
                        ll_start_o <= wdata[4] & ~busy_i;
                        restart_o  <= wdata[1];
                        stop_o     <= wdata[2];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ev_vec              = '0;
        ev_vec[EV_DESC_END] = evt_desc_end_i;
        ev_vec[EV_IDLE]     = busy_q & ~busy_i;
        ev_vec[EV_DESC_UPD] = evt_desc_upd_i;
        ev_vec[EV_PKT_DONE] = evt_pkt_done_i;
    end

    dmareg_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .ie       (cfg_o.ie),
        .ev_in    (ev_vec),
        .clr_we   (wr_en && rid == R_IP),
        .clr_mask (wdata[IRQ_W-1:0]),
        .pend     (pend),
        .irq_o    (irq_o)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (rid)
                R_SRC:    rdata = cfg_o.src;
                R_DST:    rdata = cfg_o.dst;
                R_BYTES:  rdata = cfg_o.bytes;
                R_LLHEAD: rdata = cfg_o.ll_head;
                R_INPORT: rdata[7:0]   = cfg_o.in_port;
                R_INCFG:  rdata[14:12] = cfg_o.in_cfg;
                R_OUTSTR: rdata[23:0]  = cfg_o.out_stream;
                R_OUTCFG: rdata[13:12] = cfg_o.out_cfg;
                R_PRIO: begin
                    rdata[2:0]  = cfg_o.prio;
                    rdata[10:8] = cfg_o.weight;
                end
                R_IE:     rdata[IRQ_W-1:0] = cfg_o.ie;
                R_IP:     rdata[IRQ_W-1:0] = pend;
                R_STATUS: rdata[0] = busy_i;
                R_PROG:   rdata = progress_i;
                default:  rdata = '0;
            endcase
        end
    end

    // Direct start only leaves toward an idle engine
    p_start_idle_r5: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !$past(busy_i));

    // Linked-list start also respects the busy gate
    p_llstart_idle_r5: assert property (@(posedge clk) disable iff (rst)
        ll_start_o |-> !$past(busy_i));

    // Stop pulse traces back to a status write with bit 2
    p_stop_src_r6: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> $past(wr_en && rid == R_STATUS && wdata[2]));
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_AW + OFS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_CH-1:0]    busy_i,
    input  logic [NUM_CH*32-1:0] progress_i,
    input  logic [NUM_CH-1:0]    evt_desc_end_i,
    input  logic [NUM_CH-1:0]    evt_desc_upd_i,
    input  logic [NUM_CH-1:0]    evt_pkt_done_i,
    output logic [NUM_CH*32-1:0] src_addr_o,
    output logic [NUM_CH*32-1:0] dst_addr_o,
    output logic [NUM_CH*32-1:0] byte_cnt_o,
    output logic [NUM_CH*32-1:0] ll_head_o,
    output logic [NUM_CH*8-1:0]  in_port_o,
    output logic [NUM_CH*3-1:0]  in_cfg_o,
    output logic [NUM_CH*24-1:0] out_stream_o,
    output logic [NUM_CH*2-1:0]  out_cfg_o,
    output logic [NUM_CH*3-1:0]  prio_o,
    output logic [NUM_CH*3-1:0]  weight_o,
    output logic [NUM_CH-1:0]    start_o,
    output logic [NUM_CH-1:0]    ll_start_o,
    output logic [NUM_CH-1:0]    restart_o,
    output logic [NUM_CH-1:0]    stop_o,
    output logic [NUM_CH-1:0]    irq_o
);
    logic [NUM_CH-1:0] ch_hit;
    reg_id_e           rid;
    logic [31:0]       ch_rdata [NUM_CH];
    ch_cfg_t           ch_cfg   [NUM_CH];

    dmareg_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr   (bus_addr),
        .ch_hit (ch_hit),
        .rid    (rid)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmareg_channel u_ch (
            .clk            (clk),
            .rst            (rst),
            .wr_en          (bus_sel & bus_wr & ch_hit[c]),
            .rd_en          (bus_sel & ~bus_wr & ch_hit[c]),
            .rid            (rid),
            .wdata          (bus_wdata),
            .rdata          (ch_rdata[c]),
            .busy_i         (busy_i[c]),
            .progress_i     (progress_i[c*32 +: 32]),
            .evt_desc_end_i (evt_desc_end_i[c]),
            .evt_desc_upd_i (evt_desc_upd_i[c]),
            .evt_pkt_done_i (evt_pkt_done_i[c]),
            .cfg_o          (ch_cfg[c]),
            .start_o        (start_o[c]),
            .ll_start_o     (ll_start_o[c]),
            .restart_o      (restart_o[c]),
            .stop_o         (stop_o[c]),
            .irq_o          (irq_o[c])
        );

        assign src_addr_o[c*32 +: 32]   = ch_cfg[c].src;
        assign dst_addr_o[c*32 +: 32]   = ch_cfg[c].dst;
        assign byte_cnt_o[c*32 +: 32]   = ch_cfg[c].bytes;
        assign ll_head_o[c*32 +: 32]    = ch_cfg[c].ll_head;
        assign in_port_o[c*8 +: 8]      = ch_cfg[c].in_port;
        assign in_cfg_o[c*3 +: 3]       = ch_cfg[c].in_cfg;
        assign out_stream_o[c*24 +: 24] = ch_cfg[c].out_stream;
        assign out_cfg_o[c*2 +: 2]      = ch_cfg[c].out_cfg;
        assign prio_o[c*3 +: 3]         = ch_cfg[c].prio;
        assign weight_o[c*3 +: 3]       = ch_cfg[c].weight;
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            bus_rdata = bus_rdata | ch_rdata[c];
    end

    // Unmapped offsets read as zero
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && rid == R_NONE) |-> (bus_rdata == '0));

    // Reset leaves no command pulse or interrupt behind
    p_reset_quiet_r13: assert property (@(posedge clk)
        $past(rst) |-> (start_o == '0 && stop_o == '0 && irq_o == '0));
endmodule

// File: tb/test_dmareg_top.sv
module test_dmareg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int NVEC = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0, bus_rdata;
    logic [NCH-1:0]    busy_i = '0;
    logic [NCH*32-1:0] progress_i = '0;
    logic [NCH-1:0]    ev_end = '0, ev_upd = '0, ev_pkt = '0;
    logic [NCH*32-1:0] src_addr_o, dst_addr_o, byte_cnt_o, ll_head_o;
    logic [NCH*8-1:0]  in_port_o;
    logic [NCH*3-1:0]  in_cfg_o, prio_o, weight_o;
    logic [NCH*24-1:0] out_stream_o;
    logic [NCH*2-1:0]  out_cfg_o;
    logic [NCH-1:0]    start_o, ll_start_o, restart_o, stop_o, irq_o;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmareg_top i_dmareg_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy_i(busy_i), .progress_i(progress_i),
        .evt_desc_end_i(ev_end), .evt_desc_upd_i(ev_upd), .evt_pkt_done_i(ev_pkt),
        .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .byte_cnt_o(byte_cnt_o),
        .ll_head_o(ll_head_o), .in_port_o(in_port_o), .in_cfg_o(in_cfg_o),
        .out_stream_o(out_stream_o), .out_cfg_o(out_cfg_o), .prio_o(prio_o),
        .weight_o(weight_o), .start_o(start_o), .ll_start_o(ll_start_o),
        .restart_o(restart_o), .stop_o(stop_o), .irq_o(irq_o)
    );

    // {address, write data, expected readback}
    localparam logic [73:0] VEC [NVEC] = '{
        {10'h000, 32'hDEADBEEF, 32'hDEADBEEF},
        {10'h088, 32'hFFFFFFA5, 32'h000000A5},
        {10'h10C, 32'hFFFFFFFF, 32'h00007000},
        {10'h190, 32'h12345678, 32'h12345678},
        {10'h218, 32'hAABBCCDD, 32'h00BBCCDD},
        {10'h29C, 32'hFFFFFFFF, 32'h00003000},
        {10'h320, 32'h00001000, 32'h00001000},
        {10'h3C4, 32'hFFFFFFFF, 32'h00000707},
        {10'h050, 32'hFFFFFFFF, 32'h0000001D},
        {10'h3F0, 32'hCAFEF00D, 32'hCAFEF00D},
        {10'h004, 32'hFFFFFFFF, 32'h00000000},
        {10'h0A0, 32'h00000055, 32'h00000055}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_events(input logic [NCH-1:0] e_end, input logic [NCH-1:0] e_upd,
                                input logic [NCH-1:0] e_pkt);
        @(negedge clk);
        ev_end = e_end; ev_upd = e_upd; ev_pkt = e_pkt;
        @(posedge clk); #1;
        ev_end = '0; ev_upd = '0; ev_pkt = '0;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R13: reset state
        bus_read(10'h000, rd); check("R13 src after reset", rd, 32'h0);
        bus_read(10'h3C4, rd); check("R13 prio after reset", rd, 32'h0);
        check("R13 irq after reset", {24'h0, irq_o}, 32'h0);
        check("R13 pulses after reset", {24'h0, start_o | stop_o | restart_o | ll_start_o}, 32'h0);

        // R1 R2 R12: table walk
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i][73:64], VEC[i][63:32]);
            bus_read(VEC[i][73:64], rd);
            check("R1/R2/R12 table readback", rd, VEC[i][31:0]);
        end
        bus_read(10'h000, rd); check("R12 unmapped write left ch0 src", rd, 32'hDEADBEEF);
        bus_read(10'h080, rd); check("R1 ch1 src untouched", rd, 32'h0);
        bus_read(10'h020, rd); check("R1 ch0 bytes untouched", rd, 32'h0);
        check("R12 no pulse from unmapped write", {24'h0, start_o | stop_o}, 32'h0);

        // R3: configuration outputs and field placement
        check("R3 out port field", {24'h0, out_stream_o[4*24 +: 8]}, 32'hDD);
        check("R3 source id field", {24'h0, out_stream_o[4*24+8 +: 8]}, 32'hCC);
        check("R3 sink id field", {24'h0, out_stream_o[4*24+16 +: 8]}, 32'hBB);
        check("R3 input options", {29'h0, in_cfg_o[2*3 +: 3]}, 32'h7);
        check("R3 output options", {30'h0, out_cfg_o[5*2 +: 2]}, 32'h3);
        check("R3 src output", src_addr_o[31:0], 32'hDEADBEEF);
        check("R3 prio/weight", {26'h0, weight_o[7*3 +: 3], prio_o[7*3 +: 3]}, 32'h3F);
        check("R3 ll head output", ll_head_o[7*32 +: 32], 32'hCAFEF00D);

        // R4 R5 R6: status and command pulses on channel 2
        bus_read(10'h12C, rd); check("R4 idle status", rd, 32'h0);
        bus_write(10'h12C, 32'h1);
        check("R5 start pulse", {31'h0, start_o[2]}, 32'h1);
        check("R5 only ch2 started", {24'h0, start_o}, 32'h04);
        @(posedge clk); #1;
        check("R5 start single cycle", {31'h0, start_o[2]}, 32'h0);
        bus_write(10'h12C, 32'h10);
        check("R5 ll start pulse", {31'h0, ll_start_o[2]}, 32'h1);
        @(negedge clk) busy_i[2] = 1'b1;
        bus_read(10'h12C, rd); check("R4 busy status", rd, 32'h1);
        bus_write(10'h12C, 32'h11);
        check("R5 start ignored while busy", {31'h0, start_o[2]}, 32'h0);
        check("R5 ll start ignored while busy", {31'h0, ll_start_o[2]}, 32'h0);
        bus_write(10'h12C, 32'h6);
        check("R6 restart while busy", {31'h0, restart_o[2]}, 32'h1);
        check("R6 stop while busy", {31'h0, stop_o[2]}, 32'h1);
        @(posedge clk); #1;
        check("R6 stop single cycle", {31'h0, stop_o[2]}, 32'h0);

        // R7: disabled event not latched on channel 3
        pulse_events(8'h08, 8'h0, 8'h0);
        bus_read(10'h1D4, rd); check("R7 disabled event ignored", rd, 32'h0);
        bus_write(10'h1D0, 32'h1D);
        pulse_events(8'h08, 8'h0, 8'h0);
        bus_read(10'h1D4, rd); check("R7 enabled desc end", rd, 32'h01);
        check("R10 irq raised", {31'h0, irq_o[3]}, 32'h1);
        pulse_events(8'h0, 8'h08, 8'h08);
        bus_read(10'h1D4, rd); check("R7 upd and pkt latched", rd, 32'h19);
        bus_write(10'h1D4, 32'h01);
        bus_read(10'h1D4, rd); check("R8 write one clears", rd, 32'h18);

        // R9: busy falling edge on channel 3
        @(negedge clk) busy_i[3] = 1'b1;
        @(negedge clk) busy_i[3] = 1'b0;
        @(posedge clk); #1;
        bus_read(10'h1D4, rd); check("R9 out-of-busy event", rd, 32'h1C);

        // R8: set wins against a simultaneous clear
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h1D4; bus_wdata = 32'h10;
        ev_pkt = 8'h08;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; ev_pkt = '0;
        bus_read(10'h1D4, rd); check("R8 set wins over clear", rd, 32'h1C);
        bus_write(10'h1D4, 32'hFFFFFFFF);
        bus_read(10'h1D4, rd); check("R8 clear all", rd, 32'h0);
        check("R10 irq drops when empty", {31'h0, irq_o[3]}, 32'h0);

        // R10: masking keeps pending
        pulse_events(8'h08, 8'h0, 8'h0);
        check("R10 irq on event", {31'h0, irq_o[3]}, 32'h1);
        bus_write(10'h1D0, 32'h0);
        check("R10 irq masked", {31'h0, irq_o[3]}, 32'h0);
        bus_read(10'h1D4, rd); check("R10 pending kept when masked", rd, 32'h01);
        check("R10 other channels quiet", {24'h0, irq_o}, 32'h0);

        // R11: progress readback on channel 5
        @(negedge clk) progress_i[5*32 +: 32] = 32'h00000777;
        bus_read(10'h2E0, rd); check("R11 progress ch5", rd, 32'h777);
        bus_read(10'h260, rd); check("R11 progress ch4", rd, 32'h0);

        // R13: reset again clears stored state
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk) rst = 1'b0;
        bus_read(10'h3F0, rd); check("R13 reset clears list head", rd, 32'h0);
        bus_read(10'h1D4, rd); check("R13 reset clears pending", rd, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule